// File: doc/BRIEF.md
# Staggered Channel Enable Sequencer

This block drives the final enable lines of a multi-channel output driver. Each channel's enable is the AND of its own on/off bit and the inverse of a global blanking input. Raising every enable at the same moment draws a large inrush current, so turn-on is spread out. Channel 0 switches on first, and each higher-numbered channel follows one programmable step after the channel below it. Turn-off happens on all affected channels at once, with no stagger.

The step length is an input counted in clock cycles. Each channel has its own delay timer. Because of this, a channel whose on bit is raised while blanking is already low waits its own index-based delay, counted from that change, and the channels that are already on are not touched. When blanking is raised during a staggered turn-on, the sequence stops and every enable falls together. The next time blanking falls, the stagger starts again from zero.

The step input should stay stable while a turn-on is in progress. If it drops, any channel that has already waited long enough under the new value switches on at the next edge.

Top module: `stagger_seq`

## Requirements
- R1: While rst_ni is low, en_o is all zeros. The clear takes effect at once, without waiting for a clock edge.
- R2: At every rising clock edge where blank_i is high, all bits of en_o go to 0 and stay 0 while blank_i remains high, whatever chan_on_i holds.
- R3: Channel 0 has no added delay. en_o[0] is 1 after the first edge at which chan_on_i[0] is 1 and blank_i is 0.
- R4: With S = step_cycles_i, en_o[n] rises at the (n*S+1)-th consecutive edge at which chan_on_i[n] is 1 and blank_i is 0. This places channel n exactly n*S cycles after channel 0.
- R5: With step_cycles_i equal to 0, every requested channel turns on at the first edge, all together.
- R6: A channel whose on bit is 0 stays off. Clearing an on bit drops that channel's enable at the next edge and leaves every other channel unchanged.
- R7: Raising blank_i during a staggered turn-on drops all enables at the next edge, including the channels already on. After blank_i falls again, every channel's delay is counted from zero.
- R8: An on bit that rises while blank_i is low starts that channel's own n*S delay from the edge where the change is first seen, independent of the channels already on.
- R9: Once an enable is 1, it stays 1 for as long as its on bit stays 1 and blank_i stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blank_i | input | 1 | Global blanking; high forces every enable off |
| chan_on_i | input | CH_N (16) | Per-channel on/off bits, bit n for channel n |
| step_cycles_i | input | STEP_W (4) | Stagger step length in clock cycles |
| en_o | output | CH_N (16) | Final per-channel enables |

## Verification
The full on-vector is released from blanking with step lengths 2, 3 and 0. The bench compares the whole enable vector on every cycle. This separates the per-channel delay n*S from an off-by-one error or from a shared timer, and step 0 shows the collapsed case. A sparse pattern (0xA5C3) shows that channels which are off stay off while their neighbours stagger normally. A blanking pulse in mid-sequence and a late on-bit rise at channel 12 show that an abort resets every timer, and that a late request times itself from its own change instead of from the earlier release.

// File: rtl/stagger_pkg.sv
package stagger_pkg;
  localparam int unsigned CH_N_DEF   = 16;
  localparam int unsigned STEP_W_DEF = 4;

  function automatic int unsigned idx_bits(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/stagger_req.sv
module stagger_req #(
  parameter int unsigned CH_N = 16
) (
  input  logic            blank_i,
  input  logic [CH_N-1:0] chan_on_i,
  output logic [CH_N-1:0] req_o
);
  // blanking overrides every on bit
  assign req_o = blank_i ? '0 : chan_on_i;
endmodule

// File: rtl/stagger_chan.sv
module stagger_chan #(
  parameter int unsigned IDX    = 0,
  parameter int unsigned STEP_W = 4,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              en_o
);
  logic en_q;

  if (IDX == 0) begin : g_direct
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b0;
      else         en_q <= req_i;
    end
  end else begin : g_timed
    logic [CNT_W-1:0] target;
    logic [CNT_W-1:0] cnt_q;

    assign target = CNT_W'(IDX) * CNT_W'(step_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
        en_q  <= 1'b0;
      end else if (!req_i) begin
        cnt_q <= '0;
        en_q  <= 1'b0;
      end else if (!en_q) begin
        // >= so a shortened step never strands a channel
        if (cnt_q >= target) en_q  <= 1'b1;
        else                 cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign en_o = en_q;

  a_r6_drop_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !en_o);

  a_r9_hold_while_requested: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && en_o) |=> en_o);

  a_r4_never_unrequested: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_o) |-> $past(req_i));
endmodule

// File: rtl/stagger_seq.sv
module stagger_seq
  import stagger_pkg::*;
#(
  parameter int unsigned CH_N   = CH_N_DEF,
  parameter int unsigned STEP_W = STEP_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              blank_i,
  input  logic [CH_N-1:0]   chan_on_i,
  input  logic [STEP_W-1:0] step_cycles_i,
  output logic [CH_N-1:0]   en_o
);
  localparam int unsigned IDX_W = idx_bits(CH_N);
  localparam int unsigned CNT_W = STEP_W + IDX_W;

  logic [CH_N-1:0] req;

  stagger_req #(.CH_N(CH_N)) u_req (
    .blank_i  (blank_i),
    .chan_on_i(chan_on_i),
    .req_o    (req)
  );

  for (genvar n = 0; n < CH_N; n++) begin : g_chan
    stagger_chan #(
      .IDX   (n),
      .STEP_W(STEP_W),
      .CNT_W (CNT_W)
    ) u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (req[n]),
      .step_i(step_cycles_i),
      .en_o  (en_o[n])
    );
  end

  a_r2_blank_forces_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |=> (en_o == '0));

  a_r3_chan0_immediate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_on_i[0] && !blank_i) |=> en_o[0]);

  a_r5_zero_step_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_cycles_i == '0 && !blank_i) |=> (en_o == $past(chan_on_i)));

  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (en_o == '0));
endmodule

// File: tb/stagger_seq_test.sv
module stagger_seq_test;
  localparam int CH_N = 16;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            blank_i = 1'b1;
  logic [CH_N-1:0] chan_on_i = '0;
  logic [3:0]      step_cycles_i = 4'd2;
  logic [CH_N-1:0] en_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  stagger_seq uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .blank_i      (blank_i),
    .chan_on_i    (chan_on_i),
    .step_cycles_i(step_cycles_i),
    .en_o         (en_o)
  );

  task automatic check(input logic [CH_N-1:0] exp, input string req);
    checks++;
    if (en_o !== exp) begin
      fails++;
      $display("FAIL %s: en_o actual=%h expected=%h at %0t", req, en_o, exp, $time);
    end
  endtask

  // channels due after m edges of continuous request with step s
  function automatic logic [CH_N-1:0] due(input int m, input int s);
    logic [CH_N-1:0] v = '0;
    for (int n = 0; n < CH_N; n++) if (m - 1 >= n * s) v[n] = 1'b1;
    return v;
  endfunction

  task automatic blank_one_edge();
    blank_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chan_on_i = '1; blank_i = 1'b0; rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check('0, "R1 reset");
    blank_i = 1'b1; rst_ni = 1'b1;
    @(negedge clk);
    check('0, "R2 blank after reset");
    chan_on_i = 16'h1234;
    repeat (4) @(negedge clk);
    check('0, "R2 blank ignores on bits");
  endtask

  task automatic t_stagger(input int s, input logic [CH_N-1:0] pat, input int cycles,
                           input string req);
    blank_one_edge();
    step_cycles_i = 4'(s); chan_on_i = pat; blank_i = 1'b0;
    for (int m = 1; m <= cycles; m++) begin
      @(negedge clk);
      check(pat & due(m, s), req);
    end
  endtask

  task automatic t_abort();
    blank_one_edge();
    step_cycles_i = 4'd2; chan_on_i = '1; blank_i = 1'b0;
    for (int m = 1; m <= 9; m++) begin
      @(negedge clk);
      check(due(m, 2), "R4 before abort");
    end
    blank_i = 1'b1;
    @(negedge clk);
    check('0, "R7 abort drops all");
    chan_on_i = 16'h00F0;
    repeat (3) @(negedge clk);
    check('0, "R2 held blank");
    chan_on_i = '1; blank_i = 1'b0;
    for (int m = 1; m <= 12; m++) begin
      @(negedge clk);
      check(due(m, 2), "R7 restart from zero");
    end
  endtask

  task automatic t_off_and_late();
    blank_one_edge();
    step_cycles_i = 4'd1; chan_on_i = '1; blank_i = 1'b0;
    repeat (20) @(negedge clk);
    check('1, "R9 all on");
    chan_on_i = 16'h0F0F;
    @(negedge clk);
    check(16'h0F0F, "R6 immediate off");
    step_cycles_i = 4'd2;
    repeat (5) @(negedge clk);
    check(16'h0F0F, "R6 others unaffected");
    chan_on_i = 16'h1F0F;
    for (int m = 1; m <= 30; m++) begin
      @(negedge clk);
      check(16'h0F0F | ((m - 1 >= 24) ? 16'h1000 : 16'h0000), "R8 late channel 12");
    end
  endtask

  task automatic t_async_reset();
    @(negedge clk);
    check(16'h1F0F, "R9 still on");
    #2 rst_ni = 1'b0;
    #1 check('0, "R1 async clear");
    @(negedge clk);
    rst_ni = 1'b1; blank_i = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_stagger(2, '1, 34, "R3/R4 step 2");
    t_stagger(3, '1, 48, "R4 step 3");
    t_stagger(0, 16'hBEEF, 3, "R5 step 0");
    t_stagger(3, 16'hA5C3, 48, "R6 sparse pattern");
    t_abort();
    t_off_and_late();
    t_async_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule